// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It takes the memory device from power-on to a usable state. After a single start pulse it drives the device reset line, clock enable, termination enable and command bus through the mandatory bring-up order. It holds the device in reset, lets the device settle with CKE low, raises CKE, then programs the four mode registers in a fixed order. It then launches the initial long impedance calibration and finally raises a ready flag.

Every interval is given at run time as a cycle count on an input, so one build serves any clock rate. Several intervals carry a floor that the block enforces itself. CKE may not rise sooner than five clocks after the command bus starts carrying NOPs. The wait before the first mode write is never shorter than five clocks. The final wait covers the longer of the DLL lock time and the calibration time. Each mode payload is supplied whole by the user. The block forces the DLL-enable bit of the MR1 payload and the DLL-reset bit of the MR0 payload to the values the sequence needs. With the default registered outputs, every pin changes one edge after the internal state that selects it.

Top module: `ddr3_init_seq`

## Requirements
- R1: While the controller reset is active and afterwards until `start` is sampled high, `dram_rst_n`, `dram_cke`, `dram_odt` and `init_done` are 0 and the bus carries deselect (`dram_cs_n` = 1).
- R2: Take the edge that samples `start` as edge 0 and write Nr = max(`rst_cycles`, 1). `dram_rst_n` then rises at edge Nr+1.
- R3: `dram_cke` is low whenever `dram_rst_n` is low. With Nc = max(`cke_wait_cycles`, 5), `dram_cke` rises exactly Nc cycles after `dram_rst_n` rises.
- R4: In each of the Nc cycles between the rise of `dram_rst_n` and the rise of `dram_cke`, the bus carries NOP. NOP is (cs_n, ras_n, cas_n, we_n) = (0, 1, 1, 1).
- R5: The first mode register write appears exactly max(`xs_cycles`, 5) cycles after `dram_cke` rises.
- R6: There are exactly four mode register writes, each with cs_n, ras_n, cas_n and we_n all 0 and each with CKE and device reset high. They come in this order: bank 2 carrying `mr2_val` unchanged, bank 3 carrying `mr3_val` unchanged, bank 1 carrying `mr1_val` with bit 0 forced to 0 (DLL enabled), and bank 0 carrying `mr0_val` with bit 8 forced to 1 (DLL reset).
- R7: Consecutive mode register writes are max(`mrd_cycles`, 1) cycles apart. The calibration command follows the bank 0 write by max(`mod_cycles`, 1) cycles.
- R8: The long calibration command is issued exactly once. It is (cs_n, ras_n, cas_n, we_n) = (0, 1, 1, 0) with bank 0 and an address where only bit 10 is set.
- R9: `init_done` rises max(`dllk_cycles`, `zqinit_cycles`, 1) cycles after the calibration command and stays high. Once `dram_cke` has risen it does not fall again.
- R10: `dram_odt` is 0 in every cycle.
- R11: Once `dram_rst_n` is high, every cycle that carries no mode write or calibration command carries NOP and never deselect.
- R12: A `start` pulse while the sequence runs, or after `init_done` is set, changes nothing on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low controller reset |
| start | input | 1 | Begins the sequence when the block is idle |
| rst_cycles | input | CNT_W | Device reset hold length in cycles |
| cke_wait_cycles | input | CNT_W | Wait from reset release to CKE rise (floor 5) |
| xs_cycles | input | CNT_W | Wait from CKE rise to the first mode write (floor 5) |
| mrd_cycles | input | CNT_W | Spacing between mode writes |
| mod_cycles | input | CNT_W | Spacing from the last mode write to calibration |
| dllk_cycles | input | CNT_W | DLL lock time after calibration is issued |
| zqinit_cycles | input | CNT_W | Initial calibration time |
| mr0_val | input | ADDR_W | MR0 payload |
| mr1_val | input | ADDR_W | MR1 payload |
| mr2_val | input | ADDR_W | MR2 payload |
| mr3_val | input | ADDR_W | MR3 payload |
| dram_rst_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| dram_odt | output | 1 | Device termination enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 3 | Bank address |
| dram_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device ready |

## Verification
The hardest points to reach are the enforced floors and the MR0-to-calibration spacing when it differs from the mode-write spacing. These only show when the user values straddle the floors and the two spacings are set independently. The stimulus therefore sweeps the mode-write spacing against the MR0 spacing. The other intervals are derived from the sweep indices so that they land below, at and above their floors, and one run sets every interval to zero. The payloads flip the DLL bits both ways. Some runs pulse `start` in the middle of the sequence and again after ready, and the event positions must still match the arithmetic.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_CKEW,
      ST_XPR,
      ST_MRS,
      ST_ZQ,
      ST_READY
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t CMD_MRS   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
   localparam cmd_pins_t CMD_ZQCL  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

   localparam int N_MR          = 4;
   localparam int CKE_PRE_FLOOR = 5;
   localparam int XPR_FLOOR     = 5;
   localparam int DLL_DIS_BIT   = 0;
   localparam int DLL_RST_BIT   = 8;
   localparam int ZQ_LONG_BIT   = 10;

   localparam logic [2:0] BA_MR0 = 3'b000;
   localparam logic [2:0] BA_MR1 = 3'b001;
   localparam logic [2:0] BA_MR2 = 3'b010;
   localparam logic [2:0] BA_MR3 = 3'b011;

   // Programming order of the mode registers: step -> bank select.
   function automatic logic [2:0] mr_bank(input logic [1:0] step);
      case (step)
         2'd0:    return BA_MR2;
         2'd1:    return BA_MR3;
         2'd2:    return BA_MR1;
         default: return BA_MR0;
      endcase
   endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   // Loadable down-counter; sits at zero once expired.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
   import ddr3_init_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] rst_cycles,
   input  logic [CNT_W-1:0] cke_wait_cycles,
   input  logic [CNT_W-1:0] xs_cycles,
   input  logic [CNT_W-1:0] mrd_cycles,
   input  logic [CNT_W-1:0] mod_cycles,
   input  logic [CNT_W-1:0] dllk_cycles,
   input  logic [CNT_W-1:0] zqinit_cycles,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_e       state_q,
   output logic [1:0]       step_q,
   output logic             issue_q
);

   localparam logic [CNT_W-1:0] FLOOR_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] FLOOR_CKE = CNT_W'(CKE_PRE_FLOOR);
   localparam logic [CNT_W-1:0] FLOOR_XPR = CNT_W'(XPR_FLOOR);
   localparam logic [1:0]       LAST_STEP = 2'(N_MR - 1);

   seq_state_e state_d;
   logic [1:0] step_d;
   logic       issue_d;
   logic [CNT_W-1:0] final_wait;

   // Length of a wait, raised to its floor, minus the cycle of entry.
   function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] fl);
      return ((v > fl) ? v : fl) - 1'b1;
   endfunction

   assign final_wait = (dllk_cycles > zqinit_cycles) ? dllk_cycles : zqinit_cycles;

   always_comb begin
      state_d  = state_q;
      step_d   = step_q;
      issue_d  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE: if (start) begin
            state_d  = ST_RST;
            tmr_load = 1'b1;
            tmr_val  = span_m1(rst_cycles, FLOOR_ONE);
         end
         ST_RST: if (tmr_done) begin
            state_d  = ST_CKEW;
            tmr_load = 1'b1;
            tmr_val  = span_m1(cke_wait_cycles, FLOOR_CKE);
         end
         ST_CKEW: if (tmr_done) begin
            state_d  = ST_XPR;
            tmr_load = 1'b1;
            tmr_val  = span_m1(xs_cycles, FLOOR_XPR);
         end
         ST_XPR: if (tmr_done) begin
            state_d  = ST_MRS;
            step_d   = 2'd0;
            issue_d  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = span_m1(mrd_cycles, FLOOR_ONE);
         end
         ST_MRS: if (tmr_done) begin
            issue_d  = 1'b1;
            tmr_load = 1'b1;
            if (step_q == LAST_STEP) begin
               state_d = ST_ZQ;
               tmr_val = span_m1(final_wait, FLOOR_ONE);
            end else begin
               step_d  = step_q + 2'd1;
               tmr_val = (step_q + 2'd1 == LAST_STEP) ? span_m1(mod_cycles, FLOOR_ONE)
                                                      : span_m1(mrd_cycles, FLOOR_ONE);
            end
         end
         ST_ZQ: if (tmr_done) begin
            state_d = ST_READY;
         end
         ST_READY: state_d = ST_READY;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= 2'd0;
         issue_q <= 1'b0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         issue_q <= issue_d;
      end
   end

   // A timed phase may only be left when its counter has run out.
   assert_wait_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_READY && state_d != state_q) |-> tmr_done);

   // Ready is terminal; a later start has no effect.
   assert_ready_terminal_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY) |=> (state_q == ST_READY));

endmodule

// File: rtl/ddr3_init_cmdgen.sv
module ddr3_init_cmdgen
   import ddr3_init_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  seq_state_e        state,
   input  logic [1:0]        step,
   input  logic              issue,
   input  logic [ADDR_W-1:0] mr0_val,
   input  logic [ADDR_W-1:0] mr1_val,
   input  logic [ADDR_W-1:0] mr2_val,
   input  logic [ADDR_W-1:0] mr3_val,
   output logic              rst_n_o,
   output logic              cke_o,
   output logic              odt_o,
   output logic              ready_o,
   output cmd_pins_t         cmd_o,
   output logic [2:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] mr_arr [N_MR];
   logic [2:0]        bank;
   logic [ADDR_W-1:0] payload;

   assign mr_arr[0] = mr0_val;
   assign mr_arr[1] = mr1_val;
   assign mr_arr[2] = mr2_val;
   assign mr_arr[3] = mr3_val;

   always_comb begin
      bank    = mr_bank(step);
      payload = mr_arr[bank[1:0]];
      if (bank == BA_MR1) payload[DLL_DIS_BIT] = 1'b0;
      if (bank == BA_MR0) payload[DLL_RST_BIT] = 1'b1;

      rst_n_o = 1'b1;
      cke_o   = 1'b1;
      odt_o   = 1'b0;
      ready_o = 1'b0;
      cmd_o   = CMD_NOP;
      ba_o    = 3'b000;
      addr_o  = '0;
      case (state)
         ST_CKEW: cke_o = 1'b0;
         ST_XPR:  cke_o = 1'b1;
         ST_MRS: if (issue) begin
            cmd_o  = CMD_MRS;
            ba_o   = bank;
            addr_o = payload;
         end
         ST_ZQ: if (issue) begin
            cmd_o               = CMD_ZQCL;
            addr_o[ZQ_LONG_BIT] = 1'b1;
         end
         ST_READY: ready_o = 1'b1;
         default: begin
            rst_n_o = 1'b0;
            cke_o   = 1'b0;
            cmd_o   = CMD_DESEL;
         end
      endcase
   end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
   import ddr3_init_pkg::*;
#(
   parameter int CNT_W   = 20,
   parameter int ADDR_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  rst_cycles,
   input  logic [CNT_W-1:0]  cke_wait_cycles,
   input  logic [CNT_W-1:0]  xs_cycles,
   input  logic [CNT_W-1:0]  mrd_cycles,
   input  logic [CNT_W-1:0]  mod_cycles,
   input  logic [CNT_W-1:0]  dllk_cycles,
   input  logic [CNT_W-1:0]  zqinit_cycles,
   input  logic [ADDR_W-1:0] mr0_val,
   input  logic [ADDR_W-1:0] mr1_val,
   input  logic [ADDR_W-1:0] mr2_val,
   input  logic [ADDR_W-1:0] mr3_val,
   output logic              dram_rst_n,
   output logic              dram_cke,
   output logic              dram_odt,
   output logic              dram_cs_n,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [2:0]        dram_ba,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              init_done
);

   if (ADDR_W <= ZQ_LONG_BIT) begin : g_bad_addr_w
      $error("ADDR_W must cover the calibration and DLL-reset address bits");
   end
   if (CNT_W < 3) begin : g_bad_cnt_w
      $error("CNT_W must hold the five-cycle floors");
   end

   seq_state_e        state_q;
   logic [1:0]        step_q;
   logic              issue_q;
   logic              tmr_load, tmr_done;
   logic [CNT_W-1:0]  tmr_val;

   logic              nx_rst_n, nx_cke, nx_odt, nx_ready;
   cmd_pins_t         nx_cmd;
   logic [2:0]        nx_ba;
   logic [ADDR_W-1:0] nx_addr;

   ddr3_init_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (start),
      .rst_cycles      (rst_cycles),
      .cke_wait_cycles (cke_wait_cycles),
      .xs_cycles       (xs_cycles),
      .mrd_cycles      (mrd_cycles),
      .mod_cycles      (mod_cycles),
      .dllk_cycles     (dllk_cycles),
      .zqinit_cycles   (zqinit_cycles),
      .tmr_done        (tmr_done),
      .tmr_load        (tmr_load),
      .tmr_val         (tmr_val),
      .state_q         (state_q),
      .step_q          (step_q),
      .issue_q         (issue_q)
   );

   ddr3_init_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   ddr3_init_cmdgen #(.ADDR_W(ADDR_W)) i_cmdgen (
      .state   (state_q),
      .step    (step_q),
      .issue   (issue_q),
      .mr0_val (mr0_val),
      .mr1_val (mr1_val),
      .mr2_val (mr2_val),
      .mr3_val (mr3_val),
      .rst_n_o (nx_rst_n),
      .cke_o   (nx_cke),
      .odt_o   (nx_odt),
      .ready_o (nx_ready),
      .cmd_o   (nx_cmd),
      .ba_o    (nx_ba),
      .addr_o  (nx_addr)
   );

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dram_rst_n <= 1'b0;
            dram_cke   <= 1'b0;
            dram_odt   <= 1'b0;
            dram_cs_n  <= 1'b1;
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_ba    <= 3'b000;
            dram_addr  <= '0;
            init_done  <= 1'b0;
         end else begin
            dram_rst_n <= nx_rst_n;
            dram_cke   <= nx_cke;
            dram_odt   <= nx_odt;
            dram_cs_n  <= nx_cmd.cs_n;
            dram_ras_n <= nx_cmd.ras_n;
            dram_cas_n <= nx_cmd.cas_n;
            dram_we_n  <= nx_cmd.we_n;
            dram_ba    <= nx_ba;
            dram_addr  <= nx_addr;
            init_done  <= nx_ready;
         end
      end
   end else begin : g_out_comb
      assign dram_rst_n = nx_rst_n;
      assign dram_cke   = nx_cke;
      assign dram_odt   = nx_odt;
      assign dram_cs_n  = nx_cmd.cs_n;
      assign dram_ras_n = nx_cmd.ras_n;
      assign dram_cas_n = nx_cmd.cas_n;
      assign dram_we_n  = nx_cmd.we_n;
      assign dram_ba    = nx_ba;
      assign dram_addr  = nx_addr;
      assign init_done  = nx_ready;
   end

   assert_cke_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_rst_n |-> !dram_cke);

   assert_cke_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dram_cke |=> dram_cke);

   assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_mrs_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cs_n && !dram_ras_n && !dram_cas_n && !dram_we_n) |-> (dram_cke && dram_rst_n));

endmodule

// File: tb/test_ddr3_init_seq.sv
module test_ddr3_init_seq;

   localparam int CNT_W  = 20;
   localparam int ADDR_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CNT_W-1:0]  rst_cycles = '0, cke_wait_cycles = '0, xs_cycles = '0;
   logic [CNT_W-1:0]  mrd_cycles = '0, mod_cycles = '0, dllk_cycles = '0, zqinit_cycles = '0;
   logic [ADDR_W-1:0] mr0_val = '0, mr1_val = '0, mr2_val = '0, mr3_val = '0;
   logic dram_rst_n, dram_cke, dram_odt, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, init_done;
   logic [2:0]        dram_ba;
   logic [ADDR_W-1:0] dram_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ddr3_init_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_ddr3_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rst_cycles(rst_cycles), .cke_wait_cycles(cke_wait_cycles), .xs_cycles(xs_cycles),
      .mrd_cycles(mrd_cycles), .mod_cycles(mod_cycles), .dllk_cycles(dllk_cycles),
      .zqinit_cycles(zqinit_cycles),
      .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
      .dram_rst_n(dram_rst_n), .dram_cke(dram_cke), .dram_odt(dram_odt),
      .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_ba(dram_ba), .dram_addr(dram_addr), .init_done(init_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_cfg(input int r, input int c, input int x, input int m, input int d,
                          input int dl, input int zq, input int a0, input int a1,
                          input int a2, input int a3, input bit poke);
      int nr, nc, nx, nm, nd, nz, k;
      int k_rst = -1, k_cke = -1, k_zq = -1, k_rdy = -1, mrs_n = 0, zq_n = 0, pre_nop = 0;
      int mrs_k[4], mrs_ba[4], mrs_ad[4];
      int zq_ba = 0, zq_ad = 0;
      bit bad_odt = 0, bad_cke = 0, bad_cmd = 0, bad_pre = 0, cke_drop = 0, rdy_drop = 0;
      nr = imax(r, 1); nc = imax(c, 5); nx = imax(x, 5);
      nm = imax(m, 1); nd = imax(d, 1); nz = imax(imax(dl, zq), 1);
      rst_cycles = CNT_W'(r); cke_wait_cycles = CNT_W'(c); xs_cycles = CNT_W'(x);
      mrd_cycles = CNT_W'(m); mod_cycles = CNT_W'(d); dllk_cycles = CNT_W'(dl);
      zqinit_cycles = CNT_W'(zq);
      mr0_val = ADDR_W'(a0); mr1_val = ADDR_W'(a1); mr2_val = ADDR_W'(a2); mr3_val = ADDR_W'(a3);

      // R1: reset and idle state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({dram_rst_n, dram_cke, dram_odt, init_done} == 4'b0000, "R1 idle pins",
          int'({dram_rst_n, dram_cke, dram_odt, init_done}), 0);
      chk(dram_cs_n == 1'b1, "R1 idle deselect", int'(dram_cs_n), 1);

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (k < 3000 && !(k_rdy >= 0 && k >= k_rdy + 4)) begin
         logic [3:0] cmd;
         cmd = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
         if (dram_odt) bad_odt = 1;
         if (!dram_rst_n && dram_cke) bad_cke = 1;
         if (dram_rst_n && k_rst < 0) k_rst = k;
         if (dram_cke && k_cke < 0) k_cke = k;
         if (k_cke >= 0 && !dram_cke) cke_drop = 1;
         if (k_rdy >= 0 && !init_done) rdy_drop = 1;
         if (init_done && k_rdy < 0) k_rdy = k;
         if (dram_rst_n && !dram_cke) begin
            if (cmd == 4'b0111) pre_nop++;
            else bad_pre = 1;
         end
         if (cmd == 4'b0000) begin
            if (mrs_n < 4) begin
               mrs_k[mrs_n] = k; mrs_ba[mrs_n] = int'(dram_ba); mrs_ad[mrs_n] = int'(dram_addr);
            end
            mrs_n++;
         end else if (cmd == 4'b0110) begin
            if (zq_n == 0) begin
               k_zq = k; zq_ba = int'(dram_ba); zq_ad = int'(dram_addr);
            end
            zq_n++;
         end else if (dram_rst_n && cmd != 4'b0111) begin
            bad_cmd = 1;
         end
         // R12: stray start pulses mid-run and after ready
         start = poke && (k == nr + 3 || (k_rdy >= 0 && k == k_rdy + 1));
         @(negedge clk);
         k++;
      end
      start = 1'b0;

      chk(k_rst == nr + 1, "R2 reset release edge", k_rst, nr + 1);
      chk(!bad_cke, "R3 cke low under reset", int'(bad_cke), 0);
      chk(k_cke - k_rst == nc, "R3 cke rise delay", k_cke - k_rst, nc);
      chk(pre_nop == nc && !bad_pre, "R4 nop before cke", pre_nop, nc);
      chk(mrs_n == 4, "R6 mode write count", mrs_n, 4);
      if (mrs_n == 4) begin
         chk(mrs_k[0] - k_cke == nx, "R5 first mode write delay", mrs_k[0] - k_cke, nx);
         chk(mrs_ba[0] == 2, "R6 first bank", mrs_ba[0], 2);
         chk(mrs_ba[1] == 3, "R6 second bank", mrs_ba[1], 3);
         chk(mrs_ba[2] == 1, "R6 third bank", mrs_ba[2], 1);
         chk(mrs_ba[3] == 0, "R6 fourth bank", mrs_ba[3], 0);
         chk(mrs_ad[0] == a2, "R6 MR2 payload", mrs_ad[0], a2);
         chk(mrs_ad[1] == a3, "R6 MR3 payload", mrs_ad[1], a3);
         chk(mrs_ad[2] == (a1 & 32'hFFFE), "R6 MR1 dll enable", mrs_ad[2], a1 & 32'hFFFE);
         chk(mrs_ad[3] == (a0 | 32'h0100), "R6 MR0 dll reset", mrs_ad[3], a0 | 32'h0100);
         for (int i = 1; i < 4; i++)
            chk(mrs_k[i] - mrs_k[i-1] == ((i == 3) ? nm : nm), "R7 mode write spacing",
                mrs_k[i] - mrs_k[i-1], nm);
         chk(k_zq - mrs_k[3] == nd, "R7 calibration spacing", k_zq - mrs_k[3], nd);
      end
      chk(zq_n == 1, "R8 calibration count", zq_n, 1);
      chk(zq_ba == 0 && zq_ad == 32'h0400, "R8 calibration address", zq_ad, 32'h0400);
      chk(k_rdy - k_zq == nz, "R9 ready delay", k_rdy - k_zq, nz);
      chk(!cke_drop && !rdy_drop, "R9 cke and ready hold", int'({cke_drop, rdy_drop}), 0);
      chk(!bad_odt, "R10 odt low", int'(bad_odt), 0);
      chk(!bad_cmd, "R11 idle bus is nop", int'(bad_cmd), 0);
      if (poke) chk(k_rst == nr + 1 && k_rdy >= 0 && !rdy_drop, "R12 start ignored", k_rdy, k_zq + nz);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // Sweep spacing against MR0 spacing; other intervals straddle their floors.
      for (int m = 1; m <= 4; m++) begin
         for (int d = 1; d <= 3; d++) begin
            run_cfg((m * 3 + d) % 4, m + d + 1, d * 2 + 1, m, d, m * 5, d * 7,
                    32'h0A50 ^ m, 32'h0040 + d, 32'h0018 + m, 32'h0004 * d,
                    (d == 2));
         end
      end
      // All intervals zero: every floor applies.
      run_cfg(0, 0, 0, 0, 0, 0, 0, 32'hFFFF, 32'hFFFF, 32'h0000, 32'h1234, 1'b1);
      // Longer intervals above every floor.
      run_cfg(40, 60, 12, 6, 9, 30, 45, 32'h0100, 32'h0001, 32'hA5A5, 32'h5A5A, 1'b1);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule